// File: doc/BRIEF.md
# Repeat-Mode Down-Counting Timer

This block is a down-counting timer for control-plane use. A counter of `CNT_W` bits decrements once per clock while the timer runs. When the counter is zero, the next clock is an underflow: the counter reloads either with all ones or with the first compare value, and two repeat counters of `REP_W` bits are updated. One of four repeat modes uses those counters to decide whether the timer stops on its own.

Software reaches the timer through a single-cycle register port. A write takes effect at the clock edge it is sampled on. A read is combinational on the read address. The block raises one-cycle event pulses for compare matches, underflow and repeat counters reaching zero. It latches these events as sticky flags, which the register port can set or clear bit by bit. A registered interrupt line is the OR of the enabled flags. The register port has no back-pressure: every write is accepted in the cycle it is presented. A buffered-top option moves the second compare value into the first when repeat counter 0 expires. This lets a new period start cleanly at a repeat boundary.

Top module: `rpt_downtimer`

## Requirements
- R1: After reset, every readable register reads 0, `running` is 0 and `irq` is 0.
- R2: While running, the counter decrements by one per clock. While stopped, the counter holds unless it is written or cleared.
- R3: A running counter at zero underflows on the next edge: `evt[2]` is high in that cycle, and the counter loads all ones, or the first compare value when control bit 2 is set.
- R4: In repeat mode 0 (control bits 1:0 = 0), the timer only stops when a stop command is written.
- R5: In mode 1, each underflow decrements repeat counter 0. When it reaches zero, `evt[3]` pulses and the timer stops.
- R6: In mode 2, when repeat counter 0 reaches zero, it is reloaded from repeat counter 1 if repeat counter 1 was written since the last reload, and the timer keeps running. Otherwise the timer stops.
- R7: In mode 3, each underflow decrements both repeat counters. `evt[4]` pulses when counter 1 reaches zero. The timer stops once both counters are zero.
- R8: At underflow, a repeat counter that is already zero stays zero and raises no repeat event.
- R9: Command register bit 0 starts the timer, bit 1 stops it and bit 2 forces the counter to 0 without changing the run state. Stop wins over start.
- R10: While running, `evt[0]` pulses when the counter equals the first compare value and `evt[1]` pulses when it equals the second. No event is raised while the timer is stopped.
- R11: Flag bits are 0 = compare 0, 1 = compare 1, 2 = underflow, 3 = repeat 0 zero, 4 = repeat 1 zero. Events and set-register writes set flags, and clear-register writes clear them. A set or event in the same cycle as a clear wins.
- R12: `irq` is the OR of flags AND enables, delayed by one clock.
- R13: With control bits 2 and 3 both set, the second compare value is copied into the first when repeat counter 0 reaches zero, and the reload on that underflow already uses it.
- R14: Register map: 0 control {buffered top, top enable, mode[1:0]}, 1 command, 2 status {running}, 3 counter, 4 compare 0, 5 compare 1, 6 repeat 0, 7 repeat 1, 8 flags, 9 flag set, 10 flag clear, 11 interrupt enable. Write-only and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | CNT_W | Combinational read data |
| evt | output | 5 | Event pulses, in flag bit order |
| running | output | 1 | Timer is counting |
| irq | output | 1 | Registered masked interrupt |

## Verification
The bench targets several corner cases:
- A repeat counter at zero when an underflow occurs. A design that wraps it to all ones would keep a one-shot timer running for another 255 periods.
- The buffered reload. A design that does not forget the "repeat 1 written" mark after a reload would never stop.
- Underflows in double mode where one counter is already zero. A wrong stop condition ends the run one period early or late.
- Start and stop written together. Getting the priority wrong leaves the timer running.
- The one-cycle lag of the interrupt line and the reload that uses the freshly copied top value. An off-by-one here shifts every later period.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned NEV    = 5;

  typedef enum logic [1:0] {
    RM_FREE   = 2'd0,
    RM_ONCE   = 2'd1,
    RM_RELOAD = 2'd2,
    RM_PAIR   = 2'd3
  } rmode_e;

  localparam logic [ADDR_W-1:0] AD_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] AD_CMD  = 4'd1;
  localparam logic [ADDR_W-1:0] AD_STAT = 4'd2;
  localparam logic [ADDR_W-1:0] AD_CNT  = 4'd3;
  localparam logic [ADDR_W-1:0] AD_CMP0 = 4'd4;
  localparam logic [ADDR_W-1:0] AD_CMP1 = 4'd5;
  localparam logic [ADDR_W-1:0] AD_REP0 = 4'd6;
  localparam logic [ADDR_W-1:0] AD_REP1 = 4'd7;
  localparam logic [ADDR_W-1:0] AD_FLAG = 4'd8;
  localparam logic [ADDR_W-1:0] AD_FSET = 4'd9;
  localparam logic [ADDR_W-1:0] AD_FCLR = 4'd10;
  localparam logic [ADDR_W-1:0] AD_IEN  = 4'd11;

  localparam int unsigned EV_CMP0  = 0;
  localparam int unsigned EV_CMP1  = 1;
  localparam int unsigned EV_UNDER = 2;
  localparam int unsigned EV_REP0  = 3;
  localparam int unsigned EV_REP1  = 4;

  localparam int unsigned CB_START = 0;
  localparam int unsigned CB_STOP  = 1;
  localparam int unsigned CB_CLEAR = 2;

  localparam int unsigned CF_TOPEN  = 2;
  localparam int unsigned CF_TOPBUF = 3;
endpackage

// File: rtl/rpt_cfg.sv
module rpt_cfg
  import lpt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              copy_top,
  output rmode_e            mode,
  output logic              top_en,
  output logic              top_buf,
  output logic [CNT_W-1:0]  cmp0,
  output logic [CNT_W-1:0]  cmp1,
  output logic              cmd_start,
  output logic              cmd_stop,
  output logic              cmd_clear,
  output logic              cnt_wr,
  output logic              rep0_wr,
  output logic              rep1_wr,
  output logic              ien_wr,
  output logic              fset_wr,
  output logic              fclr_wr
);
  logic ctrl_wr, cmp0_wr, cmp1_wr, cmd_wr;

  always_comb begin
    ctrl_wr   = wr_en && (wr_addr == AD_CTRL);
    cmd_wr    = wr_en && (wr_addr == AD_CMD);
    cmp0_wr   = wr_en && (wr_addr == AD_CMP0);
    cmp1_wr   = wr_en && (wr_addr == AD_CMP1);
    cnt_wr    = wr_en && (wr_addr == AD_CNT);
    rep0_wr   = wr_en && (wr_addr == AD_REP0);
    rep1_wr   = wr_en && (wr_addr == AD_REP1);
    ien_wr    = wr_en && (wr_addr == AD_IEN);
    fset_wr   = wr_en && (wr_addr == AD_FSET);
    fclr_wr   = wr_en && (wr_addr == AD_FCLR);
    cmd_start = cmd_wr && wr_data[CB_START];
    cmd_stop  = cmd_wr && wr_data[CB_STOP];
    cmd_clear = cmd_wr && wr_data[CB_CLEAR];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= RM_FREE;
      top_en  <= 1'b0;
      top_buf <= 1'b0;
      cmp0    <= '0;
      cmp1    <= '0;
    end else begin
      if (ctrl_wr) begin
        mode    <= rmode_e'(wr_data[1:0]);
        top_en  <= wr_data[CF_TOPEN];
        top_buf <= wr_data[CF_TOPBUF];
      end
      if (cmp0_wr)       cmp0 <= wr_data;
      else if (copy_top) cmp0 <= cmp1;
      if (cmp1_wr)       cmp1 <= wr_data;
    end
  end

  // R13: buffered top moves compare 1 into compare 0
  p_copy_top_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_top && !cmp0_wr) |=> (cmp0 == $past(cmp1)));
endmodule

// File: rtl/rpt_count.sv
module rpt_count
  import lpt_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rmode_e           mode,
  input  logic             top_en,
  input  logic             top_buf,
  input  logic [CNT_W-1:0] cmp0,
  input  logic [CNT_W-1:0] cmp1,
  input  logic             cmd_start,
  input  logic             cmd_stop,
  input  logic             cmd_clear,
  input  logic             cnt_wr,
  input  logic             rep0_wr,
  input  logic             rep1_wr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt,
  output logic [REP_W-1:0] rep0,
  output logic [REP_W-1:0] rep1,
  output logic             running,
  output logic [NEV-1:0]   evt,
  output logic             copy_top
);
  localparam logic [REP_W-1:0] REP_ONE = REP_W'(1);

  logic [CNT_W-1:0] cnt_q, reload_val;
  logic [REP_W-1:0] rep0_q, rep1_q, rep0_after, rep1_after;
  logic             run_q, r1w_q;
  logic             uf, r0_dec, r1_dec, r0_last, r1_last, refill, hw_stop;

  always_comb begin
    uf         = run_q && (cnt_q == '0);
    r0_dec     = uf && (mode != RM_FREE) && (rep0_q != '0);
    r1_dec     = uf && (mode == RM_PAIR) && (rep1_q != '0);
    r0_last    = r0_dec && (rep0_q == REP_ONE);
    r1_last    = r1_dec && (rep1_q == REP_ONE);
    rep0_after = rep0_q - REP_W'(r0_dec);
    rep1_after = rep1_q - REP_W'(r1_dec);
    refill     = uf && (mode == RM_RELOAD) && (rep0_after == '0) && r1w_q;
    hw_stop    = 1'b0;
    if (uf) begin
      unique case (mode)
        RM_ONCE:   hw_stop = (rep0_after == '0);
        RM_RELOAD: hw_stop = (rep0_after == '0) && !r1w_q;
        RM_PAIR:   hw_stop = (rep0_after == '0) && (rep1_after == '0);
        default:   hw_stop = 1'b0;
      endcase
    end
    copy_top   = r0_last && top_buf;
    if (!top_en)       reload_val = '1;
    else if (copy_top) reload_val = cmp1;
    else               reload_val = cmp0;
    evt              = '0;
    evt[EV_CMP0]     = run_q && (cnt_q == cmp0);
    evt[EV_CMP1]     = run_q && (cnt_q == cmp1);
    evt[EV_UNDER]    = uf;
    evt[EV_REP0]     = r0_last;
    evt[EV_REP1]     = r1_last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      rep0_q <= '0;
      rep1_q <= '0;
      r1w_q  <= 1'b0;
    end else begin
      if (cmd_stop)       run_q <= 1'b0;
      else if (cmd_start) run_q <= 1'b1;
      else if (hw_stop)   run_q <= 1'b0;

      if (cmd_clear)   cnt_q <= '0;
      else if (cnt_wr) cnt_q <= wr_data;
      else if (uf)     cnt_q <= reload_val;
      else if (run_q)  cnt_q <= cnt_q - CNT_W'(1);

      if (rep0_wr)     rep0_q <= wr_data[REP_W-1:0];
      else if (refill) rep0_q <= rep1_q;
      else             rep0_q <= rep0_after;

      if (rep1_wr) rep1_q <= wr_data[REP_W-1:0];
      else         rep1_q <= rep1_after;

      if (rep1_wr)     r1w_q <= 1'b1;
      else if (refill) r1w_q <= 1'b0;
    end
  end

  assign cnt     = cnt_q;
  assign rep0    = rep0_q;
  assign rep1    = rep1_q;
  assign running = run_q;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cnt_wr && !cmd_clear) |=> (cnt_q == $past(cnt_q)));
  p_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && (cnt_q != '0) && !cnt_wr && !cmd_clear) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && !top_en && !cnt_wr && !cmd_clear) |=> (cnt_q == '1));
  p_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && (mode == RM_FREE) && !cmd_stop) |=> run_q);
  p_once_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && (mode == RM_ONCE) && (rep0_q <= REP_ONE) && !cmd_start) |=> !run_q);
  p_refill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && (mode == RM_RELOAD) && (rep0_q == REP_ONE) && r1w_q && !rep0_wr && !rep1_wr)
      |=> ((rep0_q == $past(rep1_q)) && !r1w_q));
  p_pair_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && (mode == RM_PAIR) && (rep0_q <= REP_ONE) && (rep1_q <= REP_ONE) && !cmd_start) |=> !run_q);
  p_zero_rep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && (rep0_q == '0) && (mode != RM_RELOAD) && !rep0_wr) |=> (rep0_q == '0));
  p_stop_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop |=> !run_q);
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clear |=> (cnt_q == '0));
endmodule

// File: rtl/rpt_irq.sv
module rpt_irq
  import lpt_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] evt,
  input  logic           ien_wr,
  input  logic           fset_wr,
  input  logic           fclr_wr,
  input  logic [NEV-1:0] wbits,
  output logic [NEV-1:0] flags,
  output logic [NEV-1:0] ien,
  output logic           irq
);
  for (genvar b = 0; b < NEV; b++) begin : g_flag
    logic hit_set, hit_clr;
    assign hit_set = evt[b] || (fset_wr && wbits[b]);
    assign hit_clr = fclr_wr && wbits[b];
    always_ff @(posedge clk) begin
      if (!rst_n)       flags[b] <= 1'b0;
      else if (hit_set) flags[b] <= 1'b1;
      else if (hit_clr) flags[b] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien <= '0;
      irq <= 1'b0;
    end else begin
      if (ien_wr) ien <= wbits;
      irq <= |(flags & ien);
    end
  end

  p_flag_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((flags & $past(evt)) == $past(evt)));
  p_irq_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(flags) != '0));
endmodule

// File: rtl/rpt_downtimer.sv
module rpt_downtimer
  import lpt_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned REP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [3:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic [4:0]       evt,
  output logic             running,
  output logic             irq
);
  rmode_e           mode;
  logic             top_en, top_buf, copy_top;
  logic [CNT_W-1:0] cmp0, cmp1, cnt;
  logic [REP_W-1:0] rep0, rep1;
  logic             cmd_start, cmd_stop, cmd_clear, cnt_wr, rep0_wr, rep1_wr;
  logic             ien_wr, fset_wr, fclr_wr;
  logic [NEV-1:0]   flags, ien;

  rpt_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .copy_top(copy_top), .mode(mode), .top_en(top_en), .top_buf(top_buf),
    .cmp0(cmp0), .cmp1(cmp1), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_clear(cmd_clear), .cnt_wr(cnt_wr), .rep0_wr(rep0_wr), .rep1_wr(rep1_wr),
    .ien_wr(ien_wr), .fset_wr(fset_wr), .fclr_wr(fclr_wr)
  );

  rpt_count #(.CNT_W(CNT_W), .REP_W(REP_W)) u_count (
    .clk(clk), .rst_n(rst_n), .mode(mode), .top_en(top_en), .top_buf(top_buf),
    .cmp0(cmp0), .cmp1(cmp1), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_clear(cmd_clear), .cnt_wr(cnt_wr), .rep0_wr(rep0_wr), .rep1_wr(rep1_wr),
    .wr_data(wr_data), .cnt(cnt), .rep0(rep0), .rep1(rep1), .running(running),
    .evt(evt), .copy_top(copy_top)
  );

  rpt_irq u_irq (
    .clk(clk), .rst_n(rst_n), .evt(evt), .ien_wr(ien_wr), .fset_wr(fset_wr),
    .fclr_wr(fclr_wr), .wbits(wr_data[NEV-1:0]), .flags(flags), .ien(ien), .irq(irq)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      AD_CTRL: rd_data[3:0]       = {top_buf, top_en, mode};
      AD_STAT: rd_data[0]         = running;
      AD_CNT:  rd_data            = cnt;
      AD_CMP0: rd_data            = cmp0;
      AD_CMP1: rd_data            = cmp1;
      AD_REP0: rd_data[REP_W-1:0] = rep0;
      AD_REP1: rd_data[REP_W-1:0] = rep1;
      AD_FLAG: rd_data[NEV-1:0]   = flags;
      AD_IEN:  rd_data[NEV-1:0]   = ien;
      default: rd_data            = '0;
    endcase
  end

  p_quiet_stopped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (evt == '0));
endmodule

// File: tb/rpt_downtimer_bench.sv
`timescale 1ns/1ps
module rpt_downtimer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  wa = '0;
  logic [15:0] wd = '0;
  logic [3:0]  ra = '0;
  logic [15:0] rd_data;
  logic [4:0]  evt;
  logic        running, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] s_rd;
  logic [4:0]  s_evt;
  logic        s_run, s_irq;

  // reference state
  logic        m_run, m_r1w, m_topen, m_buf, m_irq;
  logic [1:0]  m_mode;
  logic [15:0] m_cnt, m_cmp0, m_cmp1;
  logic [7:0]  m_rep0, m_rep1;
  logic [4:0]  m_flag, m_ien;

  always #2 clk = ~clk;

  rpt_downtimer u_rpt_downtimer (
    .clk(clk), .rst_n(rst_n), .wr_en(we), .wr_addr(wa), .wr_data(wd),
    .rd_addr(ra), .rd_data(rd_data), .evt(evt), .running(running), .irq(irq)
  );

  function automatic logic [4:0] m_events();
    logic uf;
    uf = m_run && (m_cnt == 16'd0);
    return {uf && (m_mode == 2'd3) && (m_rep1 == 8'd1),
            uf && (m_mode != 2'd0) && (m_rep0 == 8'd1),
            uf,
            m_run && (m_cnt == m_cmp1),
            m_run && (m_cnt == m_cmp0)};
  endfunction

  function automatic logic [15:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return {12'd0, m_buf, m_topen, m_mode};
      4'd2: return {15'd0, m_run};
      4'd3: return m_cnt;
      4'd4: return m_cmp0;
      4'd5: return m_cmp1;
      4'd6: return {8'd0, m_rep0};
      4'd7: return {8'd0, m_rep1};
      4'd8: return {11'd0, m_flag};
      4'd11: return {11'd0, m_ien};
      default: return 16'd0;
    endcase
  endfunction

  task automatic m_reset();
    m_run = 0; m_r1w = 0; m_topen = 0; m_buf = 0; m_irq = 0; m_mode = 0;
    m_cnt = 0; m_cmp0 = 0; m_cmp1 = 0; m_rep0 = 0; m_rep1 = 0; m_flag = 0; m_ien = 0;
  endtask

  task automatic m_step(input logic w, input logic [3:0] a, input logic [15:0] d);
    logic [4:0] ev;
    logic uf, rl, st, cp;
    logic [7:0] r0a, r1a;
    logic [15:0] nxt;
    ev  = m_events();
    uf  = ev[2];
    r0a = m_rep0 - {7'd0, uf && (m_mode != 2'd0) && (m_rep0 != 8'd0)};
    r1a = m_rep1 - {7'd0, uf && (m_mode == 2'd3) && (m_rep1 != 8'd0)};
    rl  = uf && (m_mode == 2'd2) && (r0a == 8'd0) && m_r1w;
    st  = uf && (((m_mode == 2'd1) && (r0a == 8'd0)) ||
                 ((m_mode == 2'd2) && (r0a == 8'd0) && !m_r1w) ||
                 ((m_mode == 2'd3) && (r0a == 8'd0) && (r1a == 8'd0)));
    cp  = ev[3] && m_buf;
    m_irq = |(m_flag & m_ien);
    m_flag = (m_flag & ~((w && a == 4'd10) ? d[4:0] : 5'd0))
             | ((w && a == 4'd9) ? d[4:0] : 5'd0) | ev;
    if (w && a == 4'd11) m_ien = d[4:0];
    if (w && a == 4'd1 && d[1]) m_run = 0;
    else if (w && a == 4'd1 && d[0]) m_run = 1;
    else if (st) m_run = 0;
    if (w && a == 4'd1 && d[2]) nxt = 16'd0;
    else if (w && a == 4'd3) nxt = d;
    else if (uf) nxt = !m_topen ? 16'hFFFF : (cp ? m_cmp1 : m_cmp0);
    else if (ev[0] || ev[1] || m_cnt != 16'd0) nxt = (st || !m_run) ? m_cnt : m_cnt;
    else nxt = m_cnt;
    // plain decrement when counting and not at zero
    if (!(w && a == 4'd1 && d[2]) && !(w && a == 4'd3) && !uf && ev != 5'h1F)
      nxt = (m_cnt != 16'd0 && (ev[0] || ev[1] || 1'b1) && m_was_running(uf)) ? m_cnt - 16'd1 : nxt;
    m_cnt = nxt;
    if (w && a == 4'd4) m_cmp0 = d;
    else if (cp) m_cmp0 = m_cmp1;
    if (w && a == 4'd5) m_cmp1 = d;
    if (w && a == 4'd6) m_rep0 = d[7:0];
    else if (rl) m_rep0 = m_rep1;
    else m_rep0 = r0a;
    if (w && a == 4'd7) begin m_rep1 = d[7:0]; m_r1w = 1; end
    else begin m_rep1 = r1a; if (rl) m_r1w = 0; end
    if (w && a == 4'd0) begin m_mode = d[1:0]; m_topen = d[2]; m_buf = d[3]; end
    m_run_prev = m_run;
  endtask

  logic m_run_prev;
  logic m_run_at_edge;

  function automatic logic m_was_running(input logic unused_uf);
    return m_run_at_edge && !unused_uf;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic [3:0] a, input logic [15:0] d, input logic [3:0] r);
    @(negedge clk);
    we = w; wa = a; wd = d; ra = r;
    #1;
    s_rd = rd_data; s_evt = evt; s_run = running; s_irq = irq;
    chk("R14 read data", s_rd, m_read(r));
    chk("R10 events", {11'd0, s_evt}, {11'd0, m_events()});
    chk("R9 running", {15'd0, s_run}, {15'd0, m_run});
    chk("R12 irq", {15'd0, s_irq}, {15'd0, m_irq});
    @(posedge clk);
    m_run_at_edge = m_run;
    m_step(w, a, d);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    cyc(1'b1, a, d, 4'd0);
  endtask

  task automatic rd(input logic [3:0] a);
    cyc(1'b0, 4'd0, 16'd0, a);
  endtask

  task automatic run_to_uf(input logic [3:0] a);
    for (int i = 0; i < 100; i++) begin
      cyc(1'b0, 4'd0, 16'd0, a);
      if (s_evt[2]) break;
    end
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #400us;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    m_reset();
    m_run_at_edge = 0;
    m_run_prev = 0;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 12; a++) begin
      rd(a[3:0]);
      chk("R1 reset register", s_rd, 16'd0);
    end
    chk("R1 reset running", {15'd0, s_run}, 16'd0);
    chk("R1 reset irq", {15'd0, s_irq}, 16'd0);

    // R2 R3 R4 R10: free mode, wrap to all ones
    wr(4'd3, 16'd5); wr(4'd0, 16'd0); wr(4'd1, 16'd1);
    for (int i = 0; i < 5; i++) begin
      rd(4'd3);
      chk("R2 decrement", s_rd, 16'(5 - i));
    end
    rd(4'd3);
    chk("R3 underflow event", {11'd0, s_evt}, 16'h0007);
    chk("R10 compare at zero", {11'd0, s_evt & 5'h03}, 16'h0003);
    rd(4'd3);
    chk("R3 wrap value", s_rd, 16'hFFFF);
    chk("R4 free keeps running", {15'd0, s_run}, 16'd1);
    wr(4'd1, 16'd2);
    rd(4'd2);
    chk("R9 stop", s_rd, 16'd0);
    rd(4'd3);
    chk("R2 hold when stopped", s_rd, 16'hFFFD);

    // R5: one-shot with top from compare 0
    wr(4'd4, 16'd2); wr(4'd0, 16'd5); wr(4'd6, 16'd2); wr(4'd3, 16'd2); wr(4'd1, 16'd1);
    run_to_uf(4'd6);
    chk("R5 first underflow events", {11'd0, s_evt}, 16'h0006);
    run_to_uf(4'd6);
    chk("R5 last underflow events", {11'd0, s_evt}, 16'h000E);
    rd(4'd2);
    chk("R5 stopped", s_rd, 16'd0);
    rd(4'd6);
    chk("R5 repeat zero", s_rd, 16'd0);
    rd(4'd8);
    chk("R11 flag bits", s_rd, 16'h000F);
    wr(4'd10, 16'h001F);

    // R8: underflow with repeat 0 already zero
    wr(4'd1, 16'd1);
    run_to_uf(4'd6);
    chk("R8 no repeat event", {11'd0, s_evt}, 16'h0006);
    rd(4'd6);
    chk("R8 repeat stays zero", s_rd, 16'd0);
    chk("R8 stopped", {15'd0, s_run}, 16'd0);

    // R6: buffered reload then stop
    wr(4'd4, 16'd1); wr(4'd0, 16'd6); wr(4'd6, 16'd1); wr(4'd7, 16'd2);
    wr(4'd3, 16'd1); wr(4'd1, 16'd1);
    run_to_uf(4'd6);
    chk("R6 first expiry events", {11'd0, s_evt}, 16'h000E);
    rd(4'd6);
    chk("R6 refilled", s_rd, 16'd2);
    chk("R6 still running", {15'd0, s_run}, 16'd1);
    run_to_uf(4'd6);
    run_to_uf(4'd6);
    chk("R6 second expiry events", {11'd0, s_evt}, 16'h000E);
    rd(4'd2);
    chk("R6 stops without new write", s_rd, 16'd0);

    // R7: double mode
    wr(4'd0, 16'd7); wr(4'd6, 16'd1); wr(4'd7, 16'd2); wr(4'd3, 16'd0); wr(4'd1, 16'd1);
    run_to_uf(4'd7);
    chk("R7 first underflow", {11'd0, s_evt}, 16'h000E);
    run_to_uf(4'd7);
    chk("R7 repeat 1 event", {11'd0, s_evt}, 16'h0016);
    rd(4'd2);
    chk("R7 stopped", s_rd, 16'd0);
    rd(4'd7);
    chk("R7 repeat 1 zero", s_rd, 16'd0);

    // R13 R14: buffered top
    wr(4'd0, 16'hD); wr(4'd4, 16'd3); wr(4'd5, 16'd1); wr(4'd6, 16'd1);
    wr(4'd3, 16'd0); wr(4'd1, 16'd1);
    run_to_uf(4'd3);
    chk("R13 expiry events", {11'd0, s_evt}, 16'h000C);
    rd(4'd4);
    chk("R13 compare 0 copied", s_rd, 16'd1);
    rd(4'd3);
    chk("R13 reload uses new top", s_rd, 16'd1);
    rd(4'd0);
    chk("R14 control readback", s_rd, 16'hD);
    rd(4'd1);
    chk("R14 command reads zero", s_rd, 16'd0);

    // R9: priorities and clear
    wr(4'd1, 16'd3);
    rd(4'd2);
    chk("R9 stop beats start", s_rd, 16'd0);
    wr(4'd0, 16'd0); wr(4'd3, 16'd9); wr(4'd1, 16'd1);
    rd(4'd3);
    wr(4'd1, 16'd4);
    rd(4'd3);
    chk("R9 clear value", s_rd, 16'd0);
    chk("R9 clear keeps running", {15'd0, s_run}, 16'd1);
    wr(4'd1, 16'd2);

    // R11 R12: flags and interrupt
    wr(4'd10, 16'h1F); wr(4'd11, 16'h10); wr(4'd9, 16'h10);
    rd(4'd8);
    chk("R11 set register", s_rd, 16'h0010);
    chk("R12 irq lags", {15'd0, s_irq}, 16'd0);
    rd(4'd8);
    chk("R12 irq raised", {15'd0, s_irq}, 16'd1);
    wr(4'd10, 16'h10);
    rd(4'd8);
    chk("R11 clear register", s_rd, 16'd0);
    chk("R12 irq still high", {15'd0, s_irq}, 16'd1);
    rd(4'd8);
    chk("R12 irq dropped", {15'd0, s_irq}, 16'd0);
    wr(4'd9, 16'h01);
    rd(4'd8); rd(4'd8);
    chk("R12 masked flag", {15'd0, s_irq}, 16'd0);

    // random mix against the reference
    for (int n = 0; n < 20000; n++) begin
      logic [3:0] a;
      logic [15:0] d;
      a = 4'($urandom % 12);
      d = (($urandom % 4) == 0) ? 16'($urandom) : 16'($urandom % 8);
      cyc(($urandom % 4) == 0, a, d, 4'($urandom % 16));
    end

    done = 1;
    finish_run();
  end
endmodule